// File: doc/BRIEF.md
# Dual-ALU Predicated Processing Element

This block is one processing element of a two-dimensional SIMD stencil array. Every clock cycle it receives an already decoded wide instruction made of four slots: two ALU slots, one multiply-accumulate slot and one neighbour-exchange slot. It keeps ten 16-bit general registers, ten 1-bit predicate registers and a 32-bit signed accumulator.

The two 16-bit ALUs can work in one of three modes. In the first they run as two separate units. In the second they combine into one 32-bit unit that works on register pairs. In the third they form a chain, where the second unit consumes the first unit's result in the same cycle. Every slot names a predicate register and a polarity, and a slot whose predicate fails changes nothing. The exchange slot sends a register to one of the four neighbour ports and, in the same cycle, captures the value arriving from the opposite side.

Top module: `pe_core`

## Requirements
- R1: While rst_n is low, all general registers, all predicate registers and the accumulator are cleared to zero.
- R2: alu_mode 0 (independent; code 3 behaves the same): slot A writes op(R[a_src1], R[a_src2]) to R[a_dst], and slot B writes its own result to R[b_dst]. The op codes are 0 add, 1 subtract (first minus second), 2 AND, 3 OR, 4 XOR and 5 move-first.
- R3: Op 6 (signed less-than) and op 7 (equal) write 1 or 0 to predicate register P[dst] and leave the general registers alone. When no slot issues a compare, the predicate file holds its value.
- R4: alu_mode 1 (joined): slot A alone performs a 32-bit operation on pairs. The low half is in the even register and the high half in the odd register, and bit 0 of every index is forced low. The carry passes from the low half to the high half. A joined compare is signed 32-bit and writes P[a_dst], with that index used unchanged. Slot B is ignored.
- R5: alu_mode 2 (fused): the result written is opB(opA(R[a_src1], R[a_src2]), R[b_src2]) to R[b_dst], under slot B's predicate. For a compare op in slot A, its result is the difference. Slot A's destination and predicate are ignored.
- R6: A slot writes only when P[prd] XOR neg is 1. A predicate index of 10 or more reads as 1. A failed slot leaves its destination (register, predicate or accumulator) unchanged.
- R7: m_op 1 loads the accumulator with the signed product R[m_src1]*R[m_src2]. m_op 2 adds the product to the accumulator, wrapping at 32 bits. m_op 0 leaves the accumulator unchanged.
- R8: m_op 3 writes the accumulator, saturated to the signed 16-bit range (0x7FFF / 0x8000), to R[m_dst].
- R9: x_dir selects the direction: 0 north, 1 east, 2 south, 3 west. With x_en set, the selected output shows R[x_src] in the same cycle and every other output is 0. When the predicate passes, R[x_dst] captures the opposite input (north takes the south input, east takes the west input, and so on). With x_en low, all outputs are 0.
- R10: When several writers target the same register in one cycle, the exchange wins over the MAC write-back, which wins over slot B, which wins over slot A. Destinations of 10 or more are ignored, and sources of 10 or more read as 0.
- R11: All operands are read combinationally from the register state before the clock edge, and results appear after that edge. Two moves in the same cycle therefore swap registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_mode | input | 2 | 0 independent, 1 joined, 2 fused |
| a_en | input | 1 | Slot A valid |
| a_op | input | 3 | Slot A operation |
| a_dst | input | 4 | Slot A destination index |
| a_src1 | input | 4 | Slot A first source |
| a_src2 | input | 4 | Slot A second source |
| a_prd | input | 4 | Slot A predicate index |
| a_neg | input | 1 | Slot A predicate polarity |
| b_en | input | 1 | Slot B valid |
| b_op | input | 3 | Slot B operation |
| b_dst | input | 4 | Slot B destination index |
| b_src1 | input | 4 | Slot B first source |
| b_src2 | input | 4 | Slot B second source |
| b_prd | input | 4 | Slot B predicate index |
| b_neg | input | 1 | Slot B predicate polarity |
| m_op | input | 2 | MAC operation |
| m_dst | input | 4 | MAC write-back destination |
| m_src1 | input | 4 | MAC first factor |
| m_src2 | input | 4 | MAC second factor |
| m_prd | input | 4 | MAC predicate index |
| m_neg | input | 1 | MAC predicate polarity |
| x_en | input | 1 | Exchange slot valid |
| x_dir | input | 2 | Exchange direction |
| x_dst | input | 4 | Exchange capture destination |
| x_src | input | 4 | Exchange send source |
| x_prd | input | 4 | Exchange predicate index |
| x_neg | input | 1 | Exchange predicate polarity |
| nbr_n_in | input | 16 | Value from north neighbour |
| nbr_e_in | input | 16 | Value from east neighbour |
| nbr_s_in | input | 16 | Value from south neighbour |
| nbr_w_in | input | 16 | Value from west neighbour |
| nbr_n_out | output | 16 | Value sent north |
| nbr_e_out | output | 16 | Value sent east |
| nbr_s_out | output | 16 | Value sent south |
| nbr_w_out | output | 16 | Value sent west |

## Verification
Register contents are visible only through the exchange outputs. Any wrong register value therefore shows on a neighbour port in the very cycle that register is named as the send source. A corrupted predicate or accumulator stays hidden until a later predicated write or a write-back makes use of it, so it surfaces one cycle after that use. The bench reads state by sending with a predicate that always fails, and reads predicates by making a test write depend on them. In this way a stray or missing update shows up at the ports.

// File: rtl/pe_core.sv
module pe_core #(
  parameter int W     = 16,
  parameter int NREG  = 10,
  parameter int NPRED = 10,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    alu_mode,
  input  logic          a_en,
  input  logic [2:0]    a_op,
  input  logic [AW-1:0] a_dst,
  input  logic [AW-1:0] a_src1,
  input  logic [AW-1:0] a_src2,
  input  logic [AW-1:0] a_prd,
  input  logic          a_neg,
  input  logic          b_en,
  input  logic [2:0]    b_op,
  input  logic [AW-1:0] b_dst,
  input  logic [AW-1:0] b_src1,
  input  logic [AW-1:0] b_src2,
  input  logic [AW-1:0] b_prd,
  input  logic          b_neg,
  input  logic [1:0]    m_op,
  input  logic [AW-1:0] m_dst,
  input  logic [AW-1:0] m_src1,
  input  logic [AW-1:0] m_src2,
  input  logic [AW-1:0] m_prd,
  input  logic          m_neg,
  input  logic          x_en,
  input  logic [1:0]    x_dir,
  input  logic [AW-1:0] x_dst,
  input  logic [AW-1:0] x_src,
  input  logic [AW-1:0] x_prd,
  input  logic          x_neg,
  input  logic [W-1:0]  nbr_n_in,
  input  logic [W-1:0]  nbr_e_in,
  input  logic [W-1:0]  nbr_s_in,
  input  logic [W-1:0]  nbr_w_in,
  output logic [W-1:0]  nbr_n_out,
  output logic [W-1:0]  nbr_e_out,
  output logic [W-1:0]  nbr_s_out,
  output logic [W-1:0]  nbr_w_out
);
  localparam int AccW = 2 * W;
  localparam logic [2:0] OP_ADD = 3'd0, OP_AND = 3'd2, OP_OR = 3'd3,
                         OP_XOR = 3'd4, OP_MOV = 3'd5, OP_CLT = 3'd6;
  localparam logic [1:0] MODE_JOIN = 2'd1, MODE_FUSE = 2'd2;
  localparam logic signed [AccW-1:0] SMAX = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [AccW-1:0] SMIN = {{(W+1){1'b1}}, {(W-1){1'b0}}};

  logic [W-1:0]           rf [NREG];
  logic [NPRED-1:0]       pf;
  logic signed [AccW-1:0] acc;

  function automatic logic [W-1:0] rd(input logic [AW-1:0] i);
    return (int'(i) < NREG) ? rf[i] : '0;
  endfunction

  function automatic logic pok(input logic [AW-1:0] i, input logic neg);
    return ((int'(i) < NPRED) ? pf[i] : 1'b1) ^ neg;
  endfunction

  // result layout: {carry out, signed overflow, value}
  function automatic logic [W+1:0] alu_f(input logic [2:0] op, input logic [W-1:0] x,
                                         input logic [W-1:0] y, input logic ci);
    logic [W-1:0] yy, r;
    logic [W:0]   s;
    yy = (op == OP_ADD) ? y : ~y;
    s  = {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, ci};
    case (op)
      OP_AND:  r = x & y;
      OP_OR:   r = x | y;
      OP_XOR:  r = x ^ y;
      OP_MOV:  r = x;
      default: r = s[W-1:0];
    endcase
    return {s[W], (x[W-1] == yy[W-1]) && (s[W-1] != x[W-1]), r};
  endfunction

  wire joined = (alu_mode == MODE_JOIN);
  wire fused  = (alu_mode == MODE_FUSE);

  wire [AW-1:0] a_i1 = joined ? {a_src1[AW-1:1], 1'b0} : a_src1;
  wire [AW-1:0] a_i2 = joined ? {a_src2[AW-1:1], 1'b0} : a_src2;
  wire [AW-1:0] a_wd = joined ? {a_dst[AW-1:1], 1'b0} : a_dst;
  wire [AW-1:0] b_wd = joined ? {a_dst[AW-1:1], 1'b1} : b_dst;
  wire [AW-1:0] b_pd = joined ? a_dst : b_dst;

  logic [W+1:0] ra, rb;
  logic [2:0]   b_opx;
  logic [W-1:0] b_x, b_y;
  logic         b_ci;

  assign ra    = alu_f(a_op, rd(a_i1), rd(a_i2), a_op != OP_ADD);
  assign b_opx = joined ? a_op : b_op;
  assign b_x   = joined ? rd({a_src1[AW-1:1], 1'b1}) : fused ? ra[W-1:0] : rd(b_src1);
  assign b_y   = joined ? rd({a_src2[AW-1:1], 1'b1}) : rd(b_src2);
  assign b_ci  = joined ? ra[W+1] : (b_op != OP_ADD);
  assign rb    = alu_f(b_opx, b_x, b_y, b_ci);

  wire a_cmp  = (a_op[2:1] == 2'b11);
  wire b_cmp  = (b_opx[2:1] == 2'b11);
  wire a_flag = (a_op == OP_CLT) ? (ra[W-1] ^ ra[W]) : (ra[W-1:0] == '0);
  wire b_flag = (b_opx == OP_CLT) ? (rb[W-1] ^ rb[W])
              : ((rb[W-1:0] == '0) && (!joined || ra[W-1:0] == '0));

  wire a_wr = a_en && !fused && pok(a_prd, a_neg);
  wire b_wr = joined ? a_wr : (b_en && pok(b_prd, b_neg));
  wire m_ok = pok(m_prd, m_neg);
  wire x_ok = x_en && pok(x_prd, x_neg);

  logic signed [AccW-1:0] prod;
  logic [W-1:0]           msat;
  assign prod = $signed(rd(m_src1)) * $signed(rd(m_src2));
  assign msat = (acc > SMAX) ? SMAX[W-1:0] : (acc < SMIN) ? SMIN[W-1:0] : acc[W-1:0];

  logic [W-1:0] x_in, x_val;
  assign x_val = rd(x_src);
  always_comb begin
    case (x_dir)
      2'd0:    x_in = nbr_s_in;
      2'd1:    x_in = nbr_w_in;
      2'd2:    x_in = nbr_n_in;
      default: x_in = nbr_e_in;
    endcase
  end

  assign nbr_n_out = (x_en && x_dir == 2'd0) ? x_val : '0;
  assign nbr_e_out = (x_en && x_dir == 2'd1) ? x_val : '0;
  assign nbr_s_out = (x_en && x_dir == 2'd2) ? x_val : '0;
  assign nbr_w_out = (x_en && x_dir == 2'd3) ? x_val : '0;

  // later statements take priority: A, B, MAC write-back, exchange
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      pf  <= '0;
      acc <= '0;
    end else begin
      if (a_wr && a_cmp && !joined && int'(a_dst) < NPRED) pf[a_dst] <= a_flag;
      if (b_wr && b_cmp && int'(b_pd) < NPRED)              pf[b_pd]  <= b_flag;
      if (a_wr && !a_cmp && int'(a_wd) < NREG)               rf[a_wd]  <= ra[W-1:0];
      if (b_wr && !b_cmp && int'(b_wd) < NREG)               rf[b_wd]  <= rb[W-1:0];
      if (m_ok && m_op == 2'd1) acc <= prod;
      if (m_ok && m_op == 2'd2) acc <= acc + prod;
      if (m_ok && m_op == 2'd3 && int'(m_dst) < NREG)        rf[m_dst] <= msat;
      if (x_ok && int'(x_dst) < NREG)                        rf[x_dst] <= x_in;
    end
  end
endmodule

// File: rtl/pe_core_chk.sv
module pe_core_chk #(
  parameter int W     = 16,
  parameter int NREG  = 10,
  parameter int NPRED = 10,
  parameter int AW    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        alu_mode,
  input logic              a_en,
  input logic [2:0]        a_op,
  input logic [AW-1:0]     a_dst,
  input logic [AW-1:0]     a_prd,
  input logic              a_neg,
  input logic              b_en,
  input logic [2:0]        b_op,
  input logic [1:0]        m_op,
  input logic              x_en,
  input logic [W-1:0]      nbr_n_out,
  input logic [W-1:0]      nbr_e_out,
  input logic [W-1:0]      nbr_s_out,
  input logic [W-1:0]      nbr_w_out,
  input logic [NPRED-1:0]  pf,
  input logic [2*W-1:0]    acc,
  input logic [W-1:0]      rf [NREG]
);
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (acc == '0 && pf == '0 && rf[0] == '0);
    end
  end

  assert_idle_ports_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !x_en |-> (nbr_n_out == '0 && nbr_e_out == '0 && nbr_s_out == '0 && nbr_w_out == '0));

  assert_single_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|nbr_n_out, |nbr_e_out, |nbr_s_out, |nbr_w_out}));

  assert_acc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_op == 2'd0 |=> $stable(acc));

  assert_pred_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_en && a_op[2:1] == 2'b11) && !(b_en && b_op[2:1] == 2'b11) |=> $stable(pf));

  assert_blocked_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_mode == 2'd0 && a_en && a_op[2:1] != 2'b11 && int'(a_prd) < NPRED &&
     pf[a_prd] == a_neg && !b_en && m_op != 2'd3 && !x_en && int'(a_dst) < NREG)
    |=> rf[$past(a_dst)] == $past(rf[a_dst]));
endmodule

bind pe_core pe_core_chk #(.W(W), .NREG(NREG), .NPRED(NPRED), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .alu_mode(alu_mode), .a_en(a_en), .a_op(a_op),
  .a_dst(a_dst), .a_prd(a_prd), .a_neg(a_neg), .b_en(b_en), .b_op(b_op),
  .m_op(m_op), .x_en(x_en), .nbr_n_out(nbr_n_out), .nbr_e_out(nbr_e_out),
  .nbr_s_out(nbr_s_out), .nbr_w_out(nbr_w_out), .pf(pf), .acc(acc), .rf(rf)
);

// File: tb/pe_core_test.sv
`timescale 1ns/1ps
module pe_core_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] alu_mode, m_op, x_dir;
  logic a_en, a_neg, b_en, b_neg, m_neg, x_en, x_neg;
  logic [2:0] a_op, b_op;
  logic [3:0] a_dst, a_src1, a_src2, a_prd, b_dst, b_src1, b_src2, b_prd;
  logic [3:0] m_dst, m_src1, m_src2, m_prd, x_dst, x_src, x_prd;
  logic [15:0] nbr_n_in, nbr_e_in, nbr_s_in, nbr_w_in;
  logic [15:0] nbr_n_out, nbr_e_out, nbr_s_out, nbr_w_out;
  int checks = 0, errors = 0;
  logic [15:0] v;
  logic pb;

  always #5 clk = ~clk;

  pe_core uut (.*);

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic nop();
    alu_mode = 2'd0; a_en = 0; b_en = 0; m_op = 2'd0; x_en = 0;
    a_op = 0; a_dst = 0; a_src1 = 0; a_src2 = 0; a_prd = 4'hF; a_neg = 0;
    b_op = 0; b_dst = 0; b_src1 = 0; b_src2 = 0; b_prd = 4'hF; b_neg = 0;
    m_dst = 0; m_src1 = 0; m_src2 = 0; m_prd = 4'hF; m_neg = 0;
    x_dir = 0; x_dst = 0; x_src = 0; x_prd = 4'hF; x_neg = 0;
  endtask

  task automatic step();
    @(posedge clk); #2; nop();
  endtask

  task automatic peek(input logic [3:0] r, output logic [15:0] val);
    x_en = 1; x_dir = 2'd1; x_src = r; x_prd = 4'hF; x_neg = 1;
    #1 val = nbr_e_out;
    x_en = 0; x_neg = 0;
  endtask

  task automatic load(input logic [3:0] r, input logic [15:0] val);
    x_en = 1; x_dir = 2'd1; x_dst = r; nbr_w_in = val; x_prd = 4'hF; x_neg = 0;
    step();
  endtask

  task automatic getp(input logic [3:0] k, output logic bit_o);
    logic [15:0] t;
    load(4'd9, 16'h0000);
    x_en = 1; x_dir = 2'd1; x_dst = 4'd9; nbr_w_in = 16'h0001; x_prd = k; x_neg = 0;
    step();
    peek(4'd9, t);
    bit_o = t[0];
  endtask

  task automatic sa(input logic [2:0] op, input logic [3:0] d, s1, s2);
    a_en = 1; a_op = op; a_dst = d; a_src1 = s1; a_src2 = s2;
  endtask

  task automatic sb(input logic [2:0] op, input logic [3:0] d, s1, s2);
    b_en = 1; b_op = op; b_dst = d; b_src1 = s1; b_src2 = s2;
  endtask

  task automatic t_reset();
    for (int r = 0; r < 10; r++) begin
      peek(r[3:0], v); chk("R1 register cleared", v, 16'h0);
    end
    getp(4'd0, pb); chk("R1 predicate 0 cleared", {15'h0, pb}, 16'h0);
    getp(4'd8, pb); chk("R1 predicate 8 cleared", {15'h0, pb}, 16'h0);
    m_op = 2'd3; m_dst = 4'd5; step();
    peek(4'd5, v); chk("R1 accumulator cleared", v, 16'h0);
  endtask

  task automatic t_indep();
    load(0, 16'h1234); load(1, 16'h0F0F); load(2, 16'h0005); load(3, 16'h0007);
    sa(3'd0, 4, 0, 1); sb(3'd1, 5, 2, 3); step();
    peek(4, v); chk("R2 add", v, 16'h2143);
    peek(5, v); chk("R2 sub", v, 16'hFFFE);
    sa(3'd2, 6, 0, 1); sb(3'd3, 7, 0, 1); step();
    peek(6, v); chk("R2 and", v, 16'h0204);
    peek(7, v); chk("R2 or", v, 16'h1F3F);
    sa(3'd4, 4, 0, 1); sb(3'd5, 5, 0, 3); step();
    peek(4, v); chk("R2 xor", v, 16'h1D3B);
    peek(5, v); chk("R2 move", v, 16'h1234);
    sa(3'd5, 0, 1, 0); sb(3'd5, 1, 0, 0); step();
    peek(0, v); chk("R11 swap r0", v, 16'h0F0F);
    peek(1, v); chk("R11 swap r1", v, 16'h1234);
  endtask

  task automatic t_cmp();
    load(0, 16'hFFFF); load(1, 16'h0001); load(4, 16'h4444);
    sa(3'd6, 2, 0, 1); sb(3'd7, 3, 0, 1); step();
    getp(2, pb); chk("R3 -1 lt 1", {15'h0, pb}, 16'h1);
    getp(3, pb); chk("R3 -1 eq 1", {15'h0, pb}, 16'h0);
    sa(3'd6, 2, 1, 0); sb(3'd7, 3, 0, 0); step();
    getp(2, pb); chk("R3 1 lt -1", {15'h0, pb}, 16'h0);
    getp(3, pb); chk("R3 equal", {15'h0, pb}, 16'h1);
    peek(4, v); chk("R3 compare leaves register", v, 16'h4444);
    load(0, 16'h8000); load(1, 16'h7FFF);
    sa(3'd6, 4, 0, 1); step();
    getp(4, pb); chk("R3 lt with overflow", {15'h0, pb}, 16'h1);
  endtask

  task automatic t_join();
    load(0, 16'hFFFF); load(1, 16'h0001); load(2, 16'h0001); load(3, 16'h0000);
    load(7, 16'hAAAA);
    alu_mode = 2'd1; sa(3'd0, 4, 0, 2); sb(3'd5, 7, 0, 0); step();
    peek(4, v); chk("R4 joined add low", v, 16'h0000);
    peek(5, v); chk("R4 joined add high carry", v, 16'h0002);
    peek(7, v); chk("R4 slot B ignored", v, 16'hAAAA);
    alu_mode = 2'd1; sa(3'd1, 7, 5, 3); step();
    peek(6, v); chk("R4 joined sub low", v, 16'hFFFF);
    peek(7, v); chk("R4 joined sub high borrow", v, 16'h0001);
    alu_mode = 2'd1; sa(3'd6, 5, 0, 4); step();
    getp(5, pb); chk("R4 joined signed lt", {15'h0, pb}, 16'h1);
  endtask

  task automatic t_fuse();
    load(0, 16'h0003); load(1, 16'h0004); load(2, 16'h00FF); load(8, 16'h5555);
    alu_mode = 2'd2; sa(3'd0, 8, 0, 1); sb(3'd4, 3, 9, 2); step();
    peek(3, v); chk("R5 fused add then xor", v, 16'h00F8);
    peek(8, v); chk("R5 slot A destination ignored", v, 16'h5555);
    alu_mode = 2'd2; sa(3'd1, 8, 0, 1); sb(3'd1, 3, 9, 2); step();
    peek(3, v); chk("R5 fused sub then sub", v, 16'hFF00);
  endtask

  task automatic t_pred();
    load(0, 16'h1111); load(4, 16'h2222); load(5, 16'h3333);
    sa(3'd7, 1, 0, 0); step();
    sa(3'd5, 4, 0, 0); a_prd = 0; a_neg = 0; step();
    peek(4, v); chk("R6 false predicate blocks", v, 16'h2222);
    sa(3'd5, 4, 0, 0); a_prd = 0; a_neg = 1; step();
    peek(4, v); chk("R6 inverted predicate writes", v, 16'h1111);
    sb(3'd5, 5, 0, 0); b_prd = 1; b_neg = 1; step();
    peek(5, v); chk("R6 inverted true predicate blocks", v, 16'h3333);
    sa(3'd7, 6, 0, 0); a_prd = 0; a_neg = 0; step();
    getp(6, pb); chk("R6 blocked compare", {15'h0, pb}, 16'h0);
  endtask

  task automatic t_mac();
    load(0, 16'd300); load(1, 16'd200); load(2, 16'd3); load(3, 16'd4); load(4, 16'hFED4);
    m_op = 2'd1; m_src1 = 2; m_src2 = 3; step();
    m_op = 2'd3; m_dst = 5; step();
    peek(5, v); chk("R7 load product", v, 16'd12);
    m_op = 2'd2; m_src1 = 2; m_src2 = 3; step();
    m_op = 2'd3; m_dst = 5; step();
    peek(5, v); chk("R7 accumulate", v, 16'd24);
    m_op = 2'd1; m_src1 = 0; m_src2 = 1; m_prd = 0; step();
    m_op = 2'd3; m_dst = 5; step();
    peek(5, v); chk("R6 blocked MAC keeps accumulator", v, 16'd24);
    m_op = 2'd1; m_src1 = 0; m_src2 = 1; step();
    m_op = 2'd3; m_dst = 5; step();
    peek(5, v); chk("R8 positive saturation", v, 16'h7FFF);
    m_op = 2'd1; m_src1 = 4; m_src2 = 1; step();
    m_op = 2'd3; m_dst = 5; step();
    peek(5, v); chk("R8 negative saturation", v, 16'h8000);
    m_op = 2'd1; m_src1 = 0; m_src2 = 1; step();
    m_op = 2'd2; m_src1 = 4; m_src2 = 1; step();
    m_op = 2'd3; m_dst = 5; step();
    peek(5, v); chk("R7 accumulate to zero", v, 16'h0000);
    m_op = 2'd1; m_src1 = 4; m_src2 = 2; step();
    m_op = 2'd3; m_dst = 5; step();
    peek(5, v); chk("R8 in-range negative", v, 16'hFC7C);
  endtask

  task automatic t_shift();
    logic [15:0] exp_in [4];
    exp_in[0] = 16'h3003; exp_in[1] = 16'h4004; exp_in[2] = 16'h1001; exp_in[3] = 16'h2002;
    load(0, 16'hA5A5);
    for (int d = 0; d < 4; d++) begin
      nbr_n_in = 16'h1001; nbr_e_in = 16'h2002; nbr_s_in = 16'h3003; nbr_w_in = 16'h4004;
      x_en = 1; x_dir = d[1:0]; x_src = 0; x_dst = 4'(d + 1);
      #1;
      chk("R9 north out", nbr_n_out, (d == 0) ? 16'hA5A5 : 16'h0);
      chk("R9 east out",  nbr_e_out, (d == 1) ? 16'hA5A5 : 16'h0);
      chk("R9 south out", nbr_s_out, (d == 2) ? 16'hA5A5 : 16'h0);
      chk("R9 west out",  nbr_w_out, (d == 3) ? 16'hA5A5 : 16'h0);
      step();
      peek(4'(d + 1), v); chk("R9 captured opposite input", v, exp_in[d]);
    end
    #1;
    chk("R9 idle outputs", nbr_n_out | nbr_e_out | nbr_s_out | nbr_w_out, 16'h0);
  endtask

  task automatic t_prio();
    load(0, 16'hA5A5); load(1, 16'h0BB0); load(2, 16'd3); load(3, 16'd4); load(6, 16'h0);
    m_op = 2'd1; m_src1 = 2; m_src2 = 3; step();
    sa(3'd5, 6, 0, 0); sb(3'd5, 6, 1, 0); m_op = 2'd3; m_dst = 6;
    x_en = 1; x_dir = 2'd1; x_dst = 6; nbr_w_in = 16'h7777; step();
    peek(6, v); chk("R10 exchange wins", v, 16'h7777);
    sa(3'd5, 6, 0, 0); sb(3'd5, 6, 1, 0); m_op = 2'd3; m_dst = 6; step();
    peek(6, v); chk("R10 MAC beats ALUs", v, 16'd12);
    sa(3'd5, 6, 0, 0); sb(3'd5, 6, 1, 0); step();
    peek(6, v); chk("R10 slot B beats slot A", v, 16'h0BB0);
    sa(3'd5, 12, 0, 0); x_en = 1; x_dir = 2'd1; x_dst = 10; nbr_w_in = 16'h9999; step();
    peek(0, v); chk("R10 out-of-range write ignored r0", v, 16'hA5A5);
    peek(6, v); chk("R10 out-of-range write ignored r6", v, 16'h0BB0);
    sa(3'd5, 8, 11, 0); step();
    peek(8, v); chk("R10 out-of-range source reads zero", v, 16'h0);
  endtask

  initial begin
    nop();
    nbr_n_in = 0; nbr_e_in = 0; nbr_s_in = 0; nbr_w_in = 0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    t_indep();
    t_cmp();
    t_join();
    t_fuse();
    t_pred();
    t_mac();
    t_shift();
    t_prio();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule